// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from one non-maskable pin, a debug-break request, eight external request pins and five on-chip peripheral request lines. It picks the most urgent pending request and compares it with the processor's current 4-bit mask level. When the request is accepted, it presents a vector number and the mask level that the processor should load.

Every pin input passes through a two-flop synchronizer. The non-maskable pin is edge-sensed, and software picks which edge triggers it. Each external pin is set on its own to low-level sensing or to falling-edge sensing. Edge-sensed requests are latched until the processor acknowledges that source. Level-sensed requests are not latched: the source must hold them until it is serviced.

A small register port holds a control register and five priority registers. Each maskable source has a 4-bit priority. The processor takes a request by pulsing the acknowledge input while the request output is high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_req` is low and every register reads zero. A zero control register means the non-maskable pin triggers on the falling edge and all external pins use low-level sensing.
- R2: The non-maskable request is taken at every mask level, with vector 11 and new mask level 15.
- R2: Control bit 8 set to 1 selects the rising edge of the non-maskable pin, and set to 0 selects the falling edge. The other edge is ignored.
- R3: A captured non-maskable edge stays pending until an acknowledge is given while it is the presented winner. That acknowledge clears it.
- R4: The debug-break request has fixed priority 15, vector 12 and new mask level 15. It is taken only when the mask is below 15, and it wins over any maskable source at priority 15.
- R5: Control bit n (n = 0..7) selects the sensing for external pin n: 0 means active-low level, 1 means falling edge. A level request ends when the pin returns high. An edge request stays latched until it is acknowledged.
- R6: The priority register map is as follows. Address 0 is control, with bits 7:0 for the pin sense and bit 8 for the non-maskable polarity. Address 1 holds pins 0..3 and address 2 holds pins 4..7, with pin 4k+j in bits 4j+3:4j. Address 3 holds peripheral 0 in bits 3:0 and peripheral 1 in bits 7:4. Address 4 holds peripherals 2 and 3 in the same bit positions. Address 5 holds peripheral 4 in bits 3:0. Unused bits and addresses read zero and ignore writes.
- R7: Peripheral source k (k = 0..4) is a synchronous active-high level request with vector 72+k.
- R8: A maskable request is accepted only if its priority is strictly greater than `cpu_mask`, so priority 0 never produces a request.
- R9: The highest pending priority wins. Ties go in this fixed order: non-maskable, debug break, external pins 0..7, then peripherals 0..4.
- R10: When an external or peripheral request is accepted, `int_level` equals that source's priority. External pin n uses vector 64+n.
- R11: After a level-sensed pin goes low, the request appears exactly two clock edges later, not after one.
- R12: An acknowledge clears only the edge latch of the source being presented. Other pending edge requests stay and are presented next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request pin, asynchronous |
| brk_req | input | 1 | Debug-break request, synchronous level |
| ext_irq_n | input | 8 | External request pins, active low, asynchronous |
| periph_req | input | 5 | Peripheral requests, synchronous active-high level |
| cpu_mask | input | 4 | Current processor mask level |
| int_ack | input | 1 | Acknowledge pulse for the presented request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| int_req | output | 1 | An accepted request is presented |
| int_vec | output | 8 | Vector number of the presented request |
| int_level | output | 4 | Mask level to load on acceptance |

## Verification
The assertions assume that `int_ack` is only raised while `int_req` is high. They also assume that the non-maskable latch is cleared only by that acknowledge, and that a pending external edge latch is dropped only by an acknowledge or a write to the control register. The bench respects these assumptions. It pulses acknowledge only after it has seen `int_req` high at a falling clock edge. It never rewrites the control register while it expects an edge latch to hold. It drives every input at the falling clock edge and keeps each edge pulse asserted for at least two clock cycles so that the synchronizer sees it.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_EXT   = 8,
  parameter int N_PER   = 5,
  parameter int VW      = 8,
  parameter int VEC_NMI = 11,
  parameter int VEC_BRK = 12,
  parameter int VEC_EXT = 64,
  parameter int VEC_PER = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic             brk_req,
  input  logic [N_EXT-1:0] ext_irq_n,
  input  logic [N_PER-1:0] periph_req,
  input  logic [3:0]       cpu_mask,
  input  logic             int_ack,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             int_req,
  output logic [VW-1:0]    int_vec,
  output logic [3:0]       int_level
);

  localparam int NS  = 2 + N_EXT + N_PER;
  localparam int IDW = $clog2(NS);
  localparam int PER_BASE = 3;

  logic [2:0]       nmi_s;
  logic [N_EXT-1:0] x1, x2, x3;
  logic             nmi_pol;
  logic [N_EXT-1:0] ext_edge;
  logic [3:0]       ext_pri [N_EXT];
  logic [3:0]       per_pri [N_PER];
  logic             nmi_pend;
  logic [N_EXT-1:0] ext_pend;

  logic [4:0]     best;
  logic [IDW-1:0] win;
  logic           take, nmi_hit;
  logic [N_EXT-1:0] ext_fall;

  assign nmi_hit  = nmi_pol ? (nmi_s[1] & ~nmi_s[2]) : (~nmi_s[1] & nmi_s[2]);
  assign ext_fall = x3 & ~x2;
  assign take     = int_ack & int_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_s <= '0;
      x1 <= '1; x2 <= '1; x3 <= '1;
    end else begin
      nmi_s <= {nmi_s[1:0], nmi_pin};
      x1 <= ext_irq_n; x2 <= x1; x3 <= x2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pol  <= 1'b0;
      ext_edge <= '0;
      for (int k = 0; k < N_EXT; k++) ext_pri[k] <= '0;
      for (int k = 0; k < N_PER; k++) per_pri[k] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 3'd0) begin
        ext_edge <= reg_wdata[N_EXT-1:0];
        nmi_pol  <= reg_wdata[N_EXT];
      end
      for (int k = 0; k < N_EXT; k++)
        if (int'(reg_addr) == 1 + k/4) ext_pri[k] <= reg_wdata[4*(k%4) +: 4];
      for (int k = 0; k < N_PER; k++)
        if (int'(reg_addr) == PER_BASE + k/2) per_pri[k] <= reg_wdata[4*(k%2) +: 4];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 3'd0) reg_rdata[N_EXT:0] = {nmi_pol, ext_edge};
    for (int k = 0; k < N_EXT; k++)
      if (int'(reg_addr) == 1 + k/4) reg_rdata[4*(k%4) +: 4] = ext_pri[k];
    for (int k = 0; k < N_PER; k++)
      if (int'(reg_addr) == PER_BASE + k/2) reg_rdata[4*(k%2) +: 4] = per_pri[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend <= 1'b0;
      ext_pend <= '0;
    end else begin
      nmi_pend <= nmi_hit | (nmi_pend & ~(take && win == IDW'(0)));
      for (int k = 0; k < N_EXT; k++)
        ext_pend[k] <= ext_edge[k] &
                       (ext_fall[k] | (ext_pend[k] & ~(take && win == IDW'(2 + k))));
    end
  end

  always_comb begin
    best = '0;
    win  = '0;
    if (nmi_pend) begin
      best = 5'd16;
      win  = IDW'(0);
    end
    if (brk_req && best < 5'd15) begin
      best = 5'd15;
      win  = IDW'(1);
    end
    for (int k = 0; k < N_EXT; k++)
      if ((ext_edge[k] ? ext_pend[k] : ~x2[k]) && {1'b0, ext_pri[k]} > best) begin
        best = {1'b0, ext_pri[k]};
        win  = IDW'(2 + k);
      end
    for (int k = 0; k < N_PER; k++)
      if (periph_req[k] && {1'b0, per_pri[k]} > best) begin
        best = {1'b0, per_pri[k]};
        win  = IDW'(2 + N_EXT + k);
      end
  end

  assign int_req   = best > {1'b0, cpu_mask};
  assign int_level = best[4] ? 4'd15 : best[3:0];

  always_comb begin
    if (win == IDW'(0))             int_vec = VW'(VEC_NMI);
    else if (win == IDW'(1))        int_vec = VW'(VEC_BRK);
    else if (int'(win) < 2 + N_EXT) int_vec = VW'(VEC_EXT + int'(win) - 2);
    else                            int_vec = VW'(VEC_PER + int'(win) - 2 - N_EXT);
  end

  a_r2_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> int_req && int_vec == VW'(VEC_NMI) && int_level == 4'd15);

  a_r3_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend && !int_ack |=> nmi_pend);

  a_r4_brk_level: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && int_vec == VW'(VEC_BRK) |-> int_level == 4'd15);

  a_r8_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && int_vec != VW'(VEC_NMI) |-> int_level > cpu_mask);

  a_r1_ack_only_when_req: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> int_req);

  for (genvar g = 0; g < N_EXT; g++) begin : g_edge_chk
    a_r5_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
      ext_pend[g] && !int_ack && !(reg_wr && reg_addr == 3'd0) |=> ext_pend[g]);
  end

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

  logic        clk = 0, rst_n = 0;
  logic        nmi_pin = 0, brk_req = 0, int_ack = 0, reg_wr = 0;
  logic [7:0]  ext_irq_n = 8'hFF;
  logic [4:0]  periph_req = '0;
  logic [3:0]  cpu_mask = '0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        int_req;
  logic [7:0]  int_vec;
  logic [3:0]  int_level;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .brk_req(brk_req),
    .ext_irq_n(ext_irq_n), .periph_req(periph_req), .cpu_mask(cpu_mask), .int_ack(int_ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_req(int_req), .int_vec(int_vec), .int_level(int_level));

  typedef struct packed {
    logic [8:0]  ctrl;
    logic [15:0] p1, p2, p3, p4, p5;
    logic [7:0]  pins_n;
    logic [4:0]  per;
    logic        brk;
    logic [3:0]  mask;
    logic        xreq;
    logic [7:0]  xvec;
    logic [3:0]  xlvl;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{9'h0, 16'h4321, 16'h0, 16'h0, 16'h0, 16'h0, 8'hFD, 5'h00, 1'b0, 4'd0,  1'b1, 8'd65, 4'd2,  "R5 "},
    '{9'h0, 16'h4321, 16'h0, 16'h0, 16'h0, 16'h0, 8'hFD, 5'h00, 1'b0, 4'd2,  1'b0, 8'd0,  4'd0,  "R8 "},
    '{9'h0, 16'h0000, 16'h0, 16'h0, 16'h0, 16'h0, 8'hFE, 5'h00, 1'b0, 4'd0,  1'b0, 8'd0,  4'd0,  "R8 "},
    '{9'h0, 16'h4321, 16'h0, 16'h0, 16'h0, 16'h0, 8'hF6, 5'h00, 1'b0, 4'd0,  1'b1, 8'd67, 4'd4,  "R9 "},
    '{9'h0, 16'h5555, 16'h0, 16'h0, 16'h0, 16'h0, 8'hF9, 5'h00, 1'b0, 4'd0,  1'b1, 8'd65, 4'd5,  "R9 "},
    '{9'h0, 16'h0000, 16'h0, 16'h0021, 16'h0043, 16'h0009, 8'hFF, 5'h15, 1'b0, 4'd0, 1'b1, 8'd76, 4'd9, "R7 "},
    '{9'h0, 16'h0000, 16'h0007, 16'h0, 16'h0007, 16'h0, 8'hEF, 5'h04, 1'b0, 4'd0, 1'b1, 8'd68, 4'd7,  "R9 "},
    '{9'h0, 16'h000F, 16'h0, 16'h0, 16'h0, 16'h0, 8'hFE, 5'h00, 1'b1, 4'd0,  1'b1, 8'd12, 4'd15, "R4 "},
    '{9'h0, 16'h000F, 16'h0, 16'h0, 16'h0, 16'h0, 8'hFF, 5'h00, 1'b1, 4'd15, 1'b0, 8'd0,  4'd0,  "R4 "},
    '{9'h0, 16'h0000, 16'h0, 16'h00C0, 16'h0, 16'h0, 8'hFF, 5'h02, 1'b0, 4'd11, 1'b1, 8'd73, 4'd12, "R10"},
    '{9'h0, 16'h0000, 16'hA000, 16'h0, 16'h0, 16'h0, 8'h7F, 5'h00, 1'b0, 4'd0, 1'b1, 8'd71, 4'd10, "R6 "},
    '{9'h0, 16'h0000, 16'h0, 16'h0, 16'h0060, 16'h0, 8'hFF, 5'h08, 1'b0, 4'd0, 1'b1, 8'd75, 4'd6,  "R7 "}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ack();
    @(negedge clk); int_ack = int_req;
    @(negedge clk); int_ack = 0;
  endtask

  task automatic idle();
    ext_irq_n = 8'hFF; periph_req = '0; brk_req = 0; cpu_mask = '0;
    cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    chk("R1", int_req, 0);
    for (int a = 0; a < 8; a++) begin rreg(3'(a), rd); chk("R1", rd, 0); end

    // R6 register map readback and ignored bits/addresses
    wreg(3'd1, 16'h1234); rreg(3'd1, rd); chk("R6", rd, 16'h1234);
    wreg(3'd3, 16'hFFFF); rreg(3'd3, rd); chk("R6", rd, 16'h00FF);
    wreg(3'd5, 16'hFFFF); rreg(3'd5, rd); chk("R6", rd, 16'h000F);
    wreg(3'd0, 16'hFFFF); rreg(3'd0, rd); chk("R6", rd, 16'h01FF);
    wreg(3'd6, 16'hFFFF); rreg(3'd6, rd); chk("R6", rd, 16'h0000);
    rreg(3'd0, rd); chk("R6", rd, 16'h01FF);
    for (int a = 0; a < 6; a++) wreg(3'(a), 16'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wreg(3'd0, {7'h0, TBL[i].ctrl});
      wreg(3'd1, TBL[i].p1); wreg(3'd2, TBL[i].p2); wreg(3'd3, TBL[i].p3);
      wreg(3'd4, TBL[i].p4); wreg(3'd5, TBL[i].p5);
      ext_irq_n = TBL[i].pins_n; periph_req = TBL[i].per;
      brk_req = TBL[i].brk; cpu_mask = TBL[i].mask;
      cyc(4);
      chk(string'(TBL[i].tag), int_req, TBL[i].xreq);
      if (TBL[i].xreq) begin
        chk(string'(TBL[i].tag), int_vec, TBL[i].xvec);
        chk(string'(TBL[i].tag), int_level, TBL[i].xlvl);
      end
      idle();
    end
    for (int a = 0; a < 6; a++) wreg(3'(a), 16'h0);

    // R11 synchronizer latency, level mode
    wreg(3'd1, 16'h0003);
    @(negedge clk); ext_irq_n = 8'hFE;
    @(negedge clk); chk("R11", int_req, 0);
    @(negedge clk); chk("R11", int_req, 1); chk("R11", int_vec, 64);
    // R5 level request ends when pin released
    ext_irq_n = 8'hFF; cyc(3); chk("R5", int_req, 0);

    // R5 edge latch held after pin returns high
    wreg(3'd0, 16'h0003); wreg(3'd1, 16'h0053);
    @(negedge clk); ext_irq_n = 8'hFC; cyc(2); ext_irq_n = 8'hFF; cyc(6);
    chk("R5", int_req, 1);
    // R12 ack clears only the presented source
    chk("R12", int_vec, 65); chk("R10", int_level, 5);
    ack(); cyc(1);
    chk("R12", int_req, 1); chk("R12", int_vec, 64); chk("R12", int_level, 3);
    ack(); cyc(1);
    chk("R12", int_req, 0);
    wreg(3'd0, 16'h0); wreg(3'd1, 16'h0);

    // R2 falling edge default, rising ignored; mask 15
    cpu_mask = 4'd15;
    @(negedge clk); nmi_pin = 1; cyc(5); chk("R2", int_req, 0);
    nmi_pin = 0; cyc(5);
    chk("R2", int_req, 1); chk("R2", int_vec, 11); chk("R2", int_level, 15);
    // R3 held until acknowledged
    cyc(6); chk("R3", int_req, 1);
    ack(); cyc(1); chk("R3", int_req, 0);
    // R2 rising selected
    wreg(3'd0, 16'h0100);
    @(negedge clk); nmi_pin = 1; cyc(5); chk("R2", int_vec, 11); chk("R2", int_req, 1);
    ack(); cyc(1); chk("R2", int_req, 0);
    nmi_pin = 0; cyc(5); chk("R2", int_req, 0);
    // R9 NMI over break over irq at 15
    cpu_mask = 0; wreg(3'd1, 16'h000F); brk_req = 1; ext_irq_n = 8'hFE;
    @(negedge clk); nmi_pin = 1; cyc(5);
    chk("R9", int_vec, 11);
    ack(); cyc(1); chk("R9", int_req, 1); chk("R9", int_vec, 12); chk("R4", int_level, 15);
    brk_req = 0; cyc(1); chk("R9", int_vec, 64); chk("R10", int_level, 15);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule